// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block is a single-channel event timer that sits on a 32-bit register bus. Software places a 64-bit start value in two word registers. It then turns the timer on through a control register. From then on, every cycle in which the `tick` strobe is high moves a 64-bit counter down by one. Software can read the live count at any time as two words. When free-running, it inverts the count to get a rising timestamp.

When the count is already zero and a tick arrives, a terminal event occurs. The event latches a status flag. The mode bit then decides what happens next. In periodic mode the counter reloads the start value, so a start value of L gives a period of L+1 ticks. In one-shot mode the counter parks at zero until software writes the control register again. The `irq` output is the status flag gated by an unmask bit. Software clears the status flag by writing 1 to it.

The bus and the tick share one clock, and the tick is an enable strobe. A parameter places the control register at one of two offsets.

The counter is driven by a three-state machine:
- `ST_OFF`: disabled, count frozen.
- `ST_RUN`: counting.
- `ST_DONE`: one-shot expired, count held at zero.

The transitions are:
- start: `ST_OFF` to `ST_RUN` on a control write with enable set. The counter loads the start value.
- stop: `ST_RUN` or `ST_DONE` to `ST_OFF` on a control write with enable clear.
- expire: `ST_RUN` to `ST_DONE` on a terminal event in one-shot mode.
- rearm: `ST_DONE` to `ST_RUN` on a control write with enable set. The counter loads the start value.
- reload: `ST_RUN` to `ST_RUN` on a terminal event in periodic mode.

Top module: `event_timer`

## Requirements
- R1: After reset, every readable register reads 0, the counter is 0, the state is `ST_OFF` and `irq` is low.
- R2: The register map uses word addresses, and address bits [1:0] are ignored.
  - 0x00 holds the start value bits [31:0] and 0x04 holds bits [63:32]. Both are read/write.
  - 0x08 reads count bits [31:0] and 0x0C reads count bits [63:32]. Both are read-only.
  - 0x18 is the status register, with the flag in bit 0.
  - Any other address reads 0.
- R3: The control register sits at 0x10 when `CTRL_AT_1C`=0 and at 0x1C when `CTRL_AT_1C`=1. Its bits are:
  - bit 0: enable.
  - bit 1: mode, where 0 is periodic and 1 is one-shot.
  - bit 2: unmask.
  - It reads back bits [2:0], and the upper bits read as 0.
- R4: A control write with enable set, made in `ST_OFF`, copies the 64-bit start value into the counter at that clock edge. Each later tick decrements the full 64-bit count by one, with a borrow across the word boundary.
- R5: In `ST_OFF`, ticks have no effect, and the count keeps the value it had when the timer was stopped.
- R6: A tick that arrives while the count is zero in `ST_RUN` sets the status flag. In periodic mode the counter reloads the start value, so the period is start value + 1 ticks.
- R7: In one-shot mode, after the terminal event the count stays at 0 and further ticks are ignored. A control write with enable set reloads the counter and resumes counting. A control write with enable clear stops the timer.
- R8: `irq` is high exactly when the status flag and the unmask bit are both 1. Masking the interrupt does not clear the flag.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. If a terminal event and a clearing write fall in the same cycle, the flag ends up set.
- R10: Writing the start value while counting does not change the running count. The new value takes effect at the next reload or start.
- R11: A control write with enable set, made in `ST_RUN`, does not reload the counter.
- R12: A control-write cycle consumes no tick. A start that coincides with a tick leaves the counter exactly at the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the tick |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe, one decrement per high cycle |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt: status flag gated by the unmask bit |

## Verification
The count registers make a wrong state visible almost at once.

A counter that failed to load shows a stale value in the first read after the start write. A missed or doubled decrement shows an off-by-one value after the very next tick.

A state machine stuck in `ST_DONE` or `ST_RUN` reveals itself on the next tick. The count either fails to move or moves when it should hold, and a misplaced expiry shows as the wrong value after exactly start value + 1 ticks.

Status-flag errors reach `irq` in the cycle after the event or clearing write.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    localparam int OFS_LOAD_LO = 'h00;
    localparam int OFS_CNT_LO  = 'h08;
    localparam int OFS_STATUS  = 'h18;
    localparam int OFS_CTRL_A  = 'h10;
    localparam int OFS_CTRL_B  = 'h1C;

    localparam int CB_EN     = 0;
    localparam int CB_MODE   = 1;
    localparam int CB_UNMASK = 2;
    localparam int CTRL_W    = 3;

    function automatic int ctrl_offset(input bit alt);
        return alt ? OFS_CTRL_B : OFS_CTRL_A;
    endfunction

endpackage

// File: rtl/evtmr_regs.sv
module evtmr_regs
    import evtmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter bit CTRL_AT_1C = 1'b0,
    localparam int NWORDS    = 2,
    localparam int CNT_W     = NWORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              status,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  load_val,
    output logic              ctrl_wr,
    output logic              status_wr,
    output logic              ctrl_en,
    output logic              ctrl_mode,
    output logic              ctrl_unmask
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ctrl_offset(CTRL_AT_1C));
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_LD_LO  = ADDR_W'(OFS_LOAD_LO);
    localparam logic [ADDR_W-1:0] A_LD_HI  = ADDR_W'(OFS_LOAD_LO + 4);
    localparam logic [ADDR_W-1:0] A_CV_LO  = ADDR_W'(OFS_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CV_HI  = ADDR_W'(OFS_CNT_LO + 4);

    logic [ADDR_W-1:0]              word_addr;
    logic [NWORDS-1:0][DATA_W-1:0]  load_q;
    logic [CTRL_W-1:0]              ctrl_q;

    assign word_addr = addr & ~ADDR_W'(3);

    // start-value words, one register per word
    for (genvar w = 0; w < NWORDS; w++) begin : g_load
        localparam logic [ADDR_W-1:0] A_W = ADDR_W'(OFS_LOAD_LO + 4 * w);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                load_q[w] <= '0;
            end else if (wr_en && word_addr == A_W) begin
                load_q[w] <= wdata;
            end
        end
    end

    assign load_val  = load_q;
    assign ctrl_wr   = wr_en && (word_addr == A_CTRL);
    assign status_wr = wr_en && (word_addr == A_STATUS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    assign ctrl_en     = ctrl_q[CB_EN];
    assign ctrl_mode   = ctrl_q[CB_MODE];
    assign ctrl_unmask = ctrl_q[CB_UNMASK];

    always_comb begin
        rdata = '0;
        case (word_addr)
            A_LD_LO:  rdata = load_q[0];
            A_LD_HI:  rdata = load_q[1];
            A_CV_LO:  rdata = cnt_val[DATA_W-1:0];
            A_CV_HI:  rdata = cnt_val[CNT_W-1:DATA_W];
            A_CTRL:   rdata = DATA_W'(ctrl_q);
            A_STATUS: rdata = DATA_W'(status);
            default:  rdata = '0;
        endcase
    end

    // R3: a control write lands in the register one edge later
    a_r3_ctrl_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ({ctrl_unmask, ctrl_mode, ctrl_en} == $past(wdata[CTRL_W-1:0])));

    // R2: start words change only through a bus write
    a_r2_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(load_val));

endmodule

// File: rtl/evtmr_core.sv
module evtmr_core
    import evtmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             wr_enable_bit,
    input  logic             mode_oneshot,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             term,
    output run_state_t       state
);

    run_state_t       state_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             at_zero;
    logic             tick_used;

    assign at_zero   = (cnt == '0);
    assign tick_used = tick && !ctrl_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (ctrl_wr && wr_enable_bit) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (ctrl_wr && !wr_enable_bit) begin
                    state_nxt = ST_OFF;
                end else if (tick_used && at_zero && mode_oneshot) begin
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                if (ctrl_wr) state_nxt = wr_enable_bit ? ST_RUN : ST_OFF;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // outputs: counter datapath and terminal event
    always_comb begin
        cnt_nxt = cnt;
        term    = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (ctrl_wr && wr_enable_bit) cnt_nxt = load_val;
            end
            ST_RUN: begin
                if (tick_used) begin
                    if (at_zero) begin
                        term = 1'b1;
                        if (!mode_oneshot) cnt_nxt = load_val;
                    end else begin
                        cnt_nxt = cnt - CNT_W'(1);
                    end
                end
            end
            ST_DONE: begin
                if (ctrl_wr && wr_enable_bit) cnt_nxt = load_val;
            end
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    // R4: start copies the start value
    a_r4_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && ctrl_wr && wr_enable_bit)
        |=> (state == ST_RUN && cnt == $past(load_val)));

    // R4: one decrement per accepted tick
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && !ctrl_wr && cnt != '0)
        |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R5: frozen while off
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !ctrl_wr) |=> $stable(cnt));

    // R6: periodic reload at terminal count
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && !ctrl_wr && cnt == '0 && !mode_oneshot)
        |=> (cnt == $past(load_val)));

    // R7: expired one-shot parks at zero
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (cnt == '0));

    // R11: rewriting enable while running keeps the count
    a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ctrl_wr && wr_enable_bit) |=> $stable(cnt));

endmodule

// File: rtl/evtmr_irq.sv
module evtmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic term,
    input  logic status_wr,
    input  logic clr_bit,
    input  logic unmask,
    output logic status,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (term) begin
            status <= 1'b1;
        end else if (status_wr && clr_bit) begin
            status <= 1'b0;
        end
    end

    assign irq = status && unmask;

    // R9: a terminal event always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> status);

    // R9: clearing write without a new event drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && clr_bit && !term) |=> !status);

    // R9: writing 0 keeps the flag
    a_r9_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!term && !(status_wr && clr_bit)) |=> $stable(status));

endmodule

// File: rtl/event_timer.sv
module event_timer
    import evtmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter bit CTRL_AT_1C = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             ctrl_wr;
    logic             status_wr;
    logic             ctrl_en;
    logic             ctrl_mode;
    logic             ctrl_unmask;
    logic             term;
    logic             status;
    run_state_t       state;

    evtmr_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CTRL_AT_1C (CTRL_AT_1C)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_we),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .cnt_val     (cnt),
        .status      (status),
        .rdata       (bus_rdata),
        .load_val    (load_val),
        .ctrl_wr     (ctrl_wr),
        .status_wr   (status_wr),
        .ctrl_en     (ctrl_en),
        .ctrl_mode   (ctrl_mode),
        .ctrl_unmask (ctrl_unmask)
    );

    evtmr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .ctrl_wr       (ctrl_wr),
        .wr_enable_bit (bus_wdata[CB_EN]),
        .mode_oneshot  (ctrl_mode),
        .load_val      (load_val),
        .cnt           (cnt),
        .term          (term),
        .state         (state)
    );

    evtmr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .term      (term),
        .status_wr (status_wr),
        .clr_bit   (bus_wdata[0]),
        .unmask    (ctrl_unmask),
        .status    (status),
        .irq       (irq)
    );

    // R8: a masked interrupt never reaches the pin
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_unmask |-> !irq);

    // R3/R5: the state machine runs only with enable set in the register
    a_r3_state_vs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> ctrl_en);

endmodule

// File: tb/tb_event_timer.sv
module tb_event_timer;

    localparam logic [4:0] A_LLO  = 5'h00;
    localparam logic [4:0] A_LHI  = 5'h04;
    localparam logic [4:0] A_CLO  = 5'h08;
    localparam logic [4:0] A_CHI  = 5'h0C;
    localparam logic [4:0] A_CTL  = 5'h10;
    localparam logic [4:0] A_ALT  = 5'h1C;
    localparam logic [4:0] A_STAT = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    event_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [31:0] ld;
        logic        md;
        logic [7:0]  nt;
        logic [31:0] ec;
        logic        es;
    } vec_t;

    // start value, mode, ticks, expected count, expected status
    localparam vec_t VEC [10] = '{
        '{32'd10, 1'b0, 8'd3,  32'd7,  1'b0},
        '{32'd10, 1'b0, 8'd10, 32'd0,  1'b0},
        '{32'd10, 1'b0, 8'd11, 32'd10, 1'b1},
        '{32'd10, 1'b0, 8'd13, 32'd8,  1'b1},
        '{32'd3,  1'b1, 8'd4,  32'd0,  1'b1},
        '{32'd3,  1'b1, 8'd9,  32'd0,  1'b1},
        '{32'd0,  1'b0, 8'd1,  32'd0,  1'b1},
        '{32'd0,  1'b1, 8'd0,  32'd0,  1'b0},
        '{32'd5,  1'b1, 8'd5,  32'd0,  1'b0},
        '{32'd1,  1'b0, 8'd5,  32'd0,  1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CLO, d);  check("R1 count lo", d, 0);
        rd(A_CHI, d);  check("R1 count hi", d, 0);
        rd(A_CTL, d);  check("R1 ctrl", d, 0);
        rd(A_STAT, d); check("R1 status", d, 0);
        rd(A_LLO, d);  check("R1 load lo", d, 0);
        check("R1 irq", irq, 0);

        // R3: readback of three bits; alternate slot unmapped; R2 low bits ignored
        wr(A_CTL, 32'hFFFF_FFF4);
        rd(A_CTL, d);  check("R3 ctrl readback", d, 32'h4);
        rd(A_ALT, d);  check("R2 unused slot", d, 0);
        rd(5'h11, d);  check("R2 byte bits ignored", d, 32'h4);
        wr(A_CTL, 0);

        // vector table: R4 R6 R7
        foreach (VEC[i]) begin
            wr(A_CTL, 0);
            wr(A_STAT, 1);
            wr(A_LLO, VEC[i].ld);
            wr(A_LHI, 0);
            wr(A_CTL, {30'd0, VEC[i].md, 1'b1});
            ticks(int'(VEC[i].nt));
            rd(A_CLO, d);  check($sformatf("R6/R7 vec%0d count", i), d, VEC[i].ec);
            rd(A_STAT, d); check($sformatf("R6/R7 vec%0d status", i), d, 32'(VEC[i].es));
        end

        // R4: borrow across words
        wr(A_CTL, 0); wr(A_STAT, 1);
        wr(A_LLO, 0); wr(A_LHI, 1);
        rd(A_LHI, d);  check("R2 load hi readback", d, 1);
        wr(A_CTL, 1);
        rd(A_CHI, d);  check("R4 start copies hi", d, 1);
        ticks(1);
        rd(A_CLO, d);  check("R4 borrow lo", d, 32'hFFFF_FFFF);
        rd(A_CHI, d);  check("R4 borrow hi", d, 0);

        // 32-bit free-running counter
        wr(A_CTL, 0);
        wr(A_LLO, 32'hFFFF_FFFF); wr(A_LHI, 0);
        wr(A_CTL, 1);
        ticks(2);
        rd(A_CLO, d);  check("R4 free count", d, 32'hFFFF_FFFD);

        // R5: ticks ignored while off
        wr(A_CTL, 0);
        ticks(3);
        rd(A_CLO, d);  check("R5 frozen", d, 32'hFFFF_FFFD);

        // R12: start together with a tick
        wr(A_LLO, 9);
        @(negedge clk);
        bus_addr = A_CTL; bus_wdata = 1; bus_we = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
        rd(A_CLO, d);  check("R12 start eats tick", d, 9);

        // R11: enable rewrite while running
        wr(A_CTL, 1);
        rd(A_CLO, d);  check("R11 no reload", d, 9);
        ticks(1);
        rd(A_CLO, d);  check("R11 still running", d, 8);

        // R10: start value change while running
        wr(A_STAT, 1);
        wr(A_LLO, 2);
        rd(A_CLO, d);  check("R10 count untouched", d, 8);
        ticks(9);
        rd(A_CLO, d);  check("R10 new value on reload", d, 2);
        rd(A_STAT, d); check("R6 status after reload", d, 1);

        // R8 masking, R9 clearing
        check("R8 masked irq low", irq, 0);
        wr(A_CTL, 4);
        check("R8 unmasked irq high", irq, 1);
        wr(A_STAT, 0);
        check("R9 write 0 keeps flag", irq, 1);
        wr(A_STAT, 1);
        check("R9 write 1 clears", irq, 0);

        // R9: set wins over clear
        wr(A_LLO, 0);
        wr(A_CTL, 5);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 1; bus_we = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
        rd(A_STAT, d); check("R9 set wins", d, 1);
        check("R8 irq follows flag", irq, 1);

        // R7: rearm and stop from expired one-shot
        wr(A_CTL, 0); wr(A_STAT, 1);
        wr(A_LLO, 2);
        wr(A_CTL, 3);
        ticks(3);
        rd(A_CLO, d);  check("R7 expired at zero", d, 0);
        wr(A_CTL, 3);
        rd(A_CLO, d);  check("R7 rearm reloads", d, 2);
        ticks(1);
        rd(A_CLO, d);  check("R7 counts after rearm", d, 1);
        wr(A_CTL, 2);
        ticks(2);
        rd(A_CLO, d);  check("R7 stop holds", d, 1);

        summary();
    end

endmodule